// File: doc/BRIEF.md
# Timer Event Status Register

This block is a small up-counting timer built around a status register of sticky event flags. The counter runs from zero to a programmable reload value and wraps. A repetition counter decides which wraps raise an update event. Two channels each compare the counter against a stored value, or latch the counter on an input edge. A break input, a trigger input and a COM strobe each raise a flag of their own. An interrupt line combines the flags with an enable mask.

Software reaches the block through a small register bus. A single address selects one of four registers: status, interrupt enable, and the two channel registers. A write strobe and a read strobe share that address. The counter configuration, the channel modes and the event inputs arrive as plain ports, all synchronous to `clk`. Each flag has its own rule for being set and cleared. That lets software service events one at a time without losing any that arrive during the service.

Top module: `tmr_evt_stat`

## Requirements
- R1: After reset every flag, the enable mask and both channel registers are zero. Status bits 4 and 3 always read 0. Address map: 0 status, 1 interrupt enable (bits 7:0), 2 channel-1 register, 3 channel-2 register. Status bits: 7 break, 6 trigger, 5 COM, 2 channel 2, 1 channel 1, 0 update.
- R2: A status write clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. If a hardware set lands in the same cycle as a clear of that flag, the flag ends up set.
- R3: While `brk_in` is high the break flag is set on every cycle. So a software clear only takes effect once `brk_in` has returned low.
- R4: With `gated` low, a rising edge on `trg_in` sets the trigger flag and restarts the counter at zero. With `gated` high, both edges of `trg_in` set the trigger flag.
- R5: A one-cycle pulse on `com_stb` sets the COM flag. Only software clears it.
- R6: A compare-mode channel (mode bit 0) whose register is at most the reload value raises its flag when the counter, while enabled, equals the register. If the register exceeds the reload value, the flag is raised on each counter overflow instead.
- R7: A capture-mode channel (mode bit 1) copies the counter into its register and raises its flag on the selected edge of its input. The two polarity bits select the edge: 00 rising, 01 falling, 10 or 11 both. A capture beats a bus write in the same cycle.
- R8: A bus read of a channel register clears that channel's flag in capture mode. It has no effect on the flag in compare mode.
- R9: The counter advances by one per cycle and returns to zero after reaching the reload value. With `gated` high it advances only while `trg_in` is high. A `ug` pulse restarts it at zero, and so does a trigger restart (R4). A restart also loads the repetition counter and produces no overflow.
- R10: On an overflow, the repetition counter reloads from `rep_cfg` if it is zero and decrements otherwise. The update flag is set on an overflow only when the repetition counter was zero and `udis` is low.
- R11: A restart by `ug` or by the trigger sets the update flag only when both `urs` and `udis` are low.
- R12: `irq` is high exactly when some status flag is set whose bit in the enable mask is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects per R8) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register, combinational |
| reload | input | CNT_W | Counter wrap value |
| rep_cfg | input | REP_W | Repetition count |
| udis | input | 1 | Suppress all update flag sets |
| urs | input | 1 | Restrict update flag sets to overflows |
| ug | input | 1 | Software restart strobe |
| ch_mode | input | 2 | Per channel: 0 compare, 1 capture |
| ch_pol | input | 4 | Two capture polarity bits per channel, channel 1 in bits 1:0 |
| ic_in | input | 2 | Capture inputs |
| brk_in | input | 1 | Break level, active high |
| trg_in | input | 1 | Trigger input |
| gated | input | 1 | Gated counting select |
| com_stb | input | 1 | COM event strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and that `rst_n` is released cleanly. They also assume that `ug` and `com_stb` are pulses and that `reload` is not lowered below the running count. The stimulus changes inputs only on falling edges. It holds `reload` steady within each phase, so the counter never has to run the full 16-bit range to wrap. Phases raise each event one at a time and then together with bus clears and reads in the same cycle. A random stretch follows, with the reload value kept fixed.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  localparam int STAT_W = 8;
  localparam int NUM_CH = 2;

  // status bit positions
  localparam int B_UPD = 0;
  localparam int B_CH  = 1;   // channel c uses bit B_CH + c
  localparam int B_COM = 5;
  localparam int B_TRG = 6;
  localparam int B_BRK = 7;

  // register map
  localparam logic [1:0] A_STAT    = 2'd0;
  localparam logic [1:0] A_IEN     = 2'd1;
  localparam logic [1:0] A_CC_BASE = 2'd2;

  // edge selection for a capture input: 00 rise, 01 fall, 1x both
  function automatic logic edge_sel(input logic prev, input logic cur,
                                    input logic [1:0] pol);
    logic up, dn;
    up = cur & ~prev;
    dn = prev & ~cur;
    case (pol)
      2'b00:   edge_sel = up;
      2'b01:   edge_sel = dn;
      default: edge_sel = up | dn;
    endcase
  endfunction

endpackage

// File: rtl/tmr_evt_count.sv
module tmr_evt_count #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  input  logic [REP_W-1:0] rep_cfg,
  input  logic             udis,
  input  logic             urs,
  input  logic             ug,
  input  logic             gated,
  input  logic             trg_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_en,
  output logic             ovf,
  output logic             rep_zero,
  output logic             upd_evt,
  output logic             trg_evt
);

  logic             trg_q;
  logic [REP_W-1:0] rep_q;
  logic             trg_up, trg_dn, restart;

  function automatic logic [REP_W-1:0] rep_next(input logic [REP_W-1:0] cur,
                                                input logic [REP_W-1:0] cfg);
    return (cur == '0) ? cfg : cur - REP_W'(1);
  endfunction

  always_comb begin
    trg_up   = trg_in & ~trg_q;
    trg_dn   = trg_q & ~trg_in;
    cnt_en   = gated ? trg_in : 1'b1;
    restart  = ug | (~gated & trg_up);
    ovf      = ~restart & cnt_en & (cnt_q == reload);
    rep_zero = (rep_q == '0);
    trg_evt  = gated ? (trg_up | trg_dn) : trg_up;
    upd_evt  = ~udis & ((ovf & rep_zero) | (restart & ~urs));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      cnt_q <= '0;
      rep_q <= '0;
    end else begin
      trg_q <= trg_in;
      if (restart) begin
        cnt_q <= '0;
        rep_q <= rep_cfg;
      end else if (ovf) begin
        cnt_q <= '0;
        rep_q <= rep_next(rep_q, rep_cfg);
      end else if (cnt_en) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R9: a software restart leaves the counter at zero
  p_ug_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt_q == '0));

  // R9: gated with the trigger low and no restart, the count holds
  p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !trg_in && !ug) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_en,
  input  logic             ovf,
  input  logic [CNT_W-1:0] reload,
  input  logic             cap_mode,
  input  logic [1:0]       pol,
  input  logic             ic_in,
  input  logic             wr_cc,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] ccr_q,
  output logic             cap_evt,
  output logic             cmp_evt
);

  logic ic_q;

  always_comb begin
    cap_evt = cap_mode & edge_sel(ic_q, ic_in, pol);
    cmp_evt = ~cap_mode &
              ((ccr_q > reload) ? ovf : (cnt_en & (cnt == ccr_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q  <= 1'b0;
      ccr_q <= '0;
    end else begin
      ic_q <= ic_in;
      if (cap_evt)    ccr_q <= cnt;
      else if (wr_cc) ccr_q <= wdata;
    end
  end

  // R7: a capture stores the counter value present at the edge
  p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ccr_q == $past(cnt)));

endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= set_i | (stat_q & ~clr_i);
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    // R2: a hardware set wins over a same-cycle clear
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> stat_q[b]);
    // R2: a clear with no set empties the flag
    p_clr_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !stat_q[b]);
  end

endmodule

// File: rtl/tmr_evt_stat.sv
module tmr_evt_stat
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16,   // also the bus data width, at least 8
  parameter int REP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [CNT_W-1:0]   reload,
  input  logic [REP_W-1:0]   rep_cfg,
  input  logic               udis,
  input  logic               urs,
  input  logic               ug,
  input  logic [NUM_CH-1:0]  ch_mode,
  input  logic [2*NUM_CH-1:0] ch_pol,
  input  logic [NUM_CH-1:0]  ic_in,
  input  logic               brk_in,
  input  logic               trg_in,
  input  logic               gated,
  input  logic               com_stb,
  output logic               irq
);

  logic [CNT_W-1:0]  cnt;
  logic              cnt_en, ovf, rep_zero, upd_evt, trg_evt;
  logic [NUM_CH-1:0] ch_hit, ch_rdclr;
  logic [CNT_W-1:0]  ccr_q [NUM_CH];
  logic [STAT_W-1:0] stat_set, stat_clr, stat_q, ien_q;
  logic              wr_stat;

  tmr_evt_count #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk, .rst_n, .reload, .rep_cfg, .udis, .urs, .ug, .gated, .trg_in,
    .cnt_q(cnt), .cnt_en, .ovf, .rep_zero, .upd_evt, .trg_evt
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic wr_cc, sel_cc, cap_evt, cmp_evt;
    assign sel_cc = (bus_addr == A_CC_BASE + 2'(gi));
    assign wr_cc  = bus_wr & sel_cc;
    assign ch_rdclr[gi] = bus_rd & sel_cc & ch_mode[gi];
    assign ch_hit[gi]   = cap_evt | cmp_evt;

    tmr_evt_chan #(.CNT_W(CNT_W)) u_ch (
      .clk, .rst_n, .cnt, .cnt_en, .ovf, .reload,
      .cap_mode(ch_mode[gi]), .pol(ch_pol[2*gi +: 2]), .ic_in(ic_in[gi]),
      .wr_cc, .wdata(bus_wdata), .ccr_q(ccr_q[gi]), .cap_evt, .cmp_evt
    );

    // R6: an out-of-range compare value flags on overflow
    p_cmp_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_mode[gi] && (ccr_q[gi] > reload) && ovf) |=> stat_q[B_CH+gi]);
    // R8: a read in capture mode with no new event clears the flag
    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_cc && ch_mode[gi] && !ch_hit[gi]) |=> !stat_q[B_CH+gi]);
  end

  assign wr_stat  = bus_wr & (bus_addr == A_STAT);
  assign stat_set = {brk_in, trg_evt, com_stb, 2'b00, ch_hit, upd_evt};
  assign stat_clr = (wr_stat ? ~bus_wdata[STAT_W-1:0] : '0) |
                    {{(STAT_W-NUM_CH-1){1'b0}}, ch_rdclr, 1'b0};

  tmr_evt_flags u_flags (
    .clk, .rst_n, .set_i(stat_set), .clr_i(stat_clr), .stat_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ien_q <= '0;
    else if (bus_wr && bus_addr == A_IEN) ien_q <= bus_wdata[STAT_W-1:0];
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = CNT_W'(stat_q);
      A_IEN:   bus_rdata = CNT_W'(ien_q);
      2'd2:    bus_rdata = ccr_q[0];
      default: bus_rdata = ccr_q[1];
    endcase
  end

  assign irq = |(stat_q & ien_q);

  // R1: reserved status bits stay zero
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[4:3] == 2'b00);
  // R3: an active break leaves the flag set whatever software writes
  p_brk_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> stat_q[B_BRK]);
  // R4: an ungated rising trigger sets its flag
  p_trg_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && $rose(trg_in)) |=> stat_q[B_TRG]);
  // R5: the COM strobe sets its flag
  p_com_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    com_stb |=> stat_q[B_COM]);
  // R10: an overflow at repetition zero raises the update flag
  p_upd_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && rep_zero && !udis) |=> stat_q[B_UPD]);
  // R11: update-disable blocks every update source
  p_upd_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    udis |-> !upd_evt);

endmodule

// File: tb/sim_tmr_evt_stat.sv
module sim_tmr_evt_stat;
  localparam int CLK_P = 10;
  localparam int CW = 16;
  localparam int RW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 0, bus_rd = 0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [CW-1:0] reload = 16'd5;
  logic [RW-1:0] rep_cfg = '0;
  logic          udis = 0, urs = 0, ug = 0;
  logic [1:0]    ch_mode = '0;
  logic [3:0]    ch_pol = '0;
  logic [1:0]    ic_in = '0;
  logic          brk_in = 0, trg_in = 0, gated = 0, com_stb = 0;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  tmr_evt_stat #(.CNT_W(CW), .REP_W(RW)) u0 (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .reload, .rep_cfg, .udis, .urs, .ug, .ch_mode, .ch_pol, .ic_in,
    .brk_in, .trg_in, .gated, .com_stb, .irq
  );

  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int       m_cnt, m_rep;
  int       m_ccr [2];
  bit [7:0] m_flag, m_ien;
  bit       m_trg_p;
  bit       m_ic_p [2];

  always @(posedge clk or negedge rst_n) begin : model
    bit run, up, dn, rst_cnt, wrap, upd, tev, cur, prv, ed;
    bit [7:0] sv, cv;
    bit hitv [2];
    bit rdc [2];
    int nccr [2];
    if (!rst_n) begin
      m_cnt = 0; m_rep = 0; m_flag = 0; m_ien = 0; m_trg_p = 0;
      for (int c = 0; c < 2; c++) begin m_ccr[c] = 0; m_ic_p[c] = 0; end
    end else begin
      up = trg_in && !m_trg_p;
      dn = !trg_in && m_trg_p;
      run = gated ? trg_in : 1'b1;
      rst_cnt = ug || (!gated && up);
      wrap = !rst_cnt && run && (m_cnt == int'(reload));
      upd = !udis && ((wrap && m_rep == 0) || (rst_cnt && !urs));
      tev = gated ? (up || dn) : up;
      for (int c = 0; c < 2; c++) begin
        cur = ic_in[c]; prv = m_ic_p[c];
        case (ch_pol[2*c +: 2])
          2'b00:   ed = cur && !prv;
          2'b01:   ed = !cur && prv;
          default: ed = cur != prv;
        endcase
        nccr[c] = m_ccr[c];
        if (bus_wr && bus_addr == 2'(2 + c)) nccr[c] = int'(bus_wdata);
        if (ch_mode[c]) begin
          hitv[c] = ed;
          if (ed) nccr[c] = m_cnt;
        end else if (m_ccr[c] > int'(reload)) hitv[c] = wrap;
        else hitv[c] = run && (m_cnt == m_ccr[c]);
        rdc[c] = bus_rd && bus_addr == 2'(2 + c) && ch_mode[c];
        m_ic_p[c] = cur;
      end
      sv = {brk_in, tev, com_stb, 2'b00, hitv[1], hitv[0], upd};
      cv = (bus_wr && bus_addr == 2'd0) ? ~bus_wdata[7:0] : 8'h00;
      if (rdc[0]) cv[1] = 1'b1;
      if (rdc[1]) cv[2] = 1'b1;
      m_flag = sv | (m_flag & ~cv);
      if (bus_wr && bus_addr == 2'd1) m_ien = bus_wdata[7:0];
      for (int c = 0; c < 2; c++) m_ccr[c] = nccr[c];
      if (rst_cnt) begin
        m_cnt = 0; m_rep = int'(rep_cfg);
      end else if (wrap) begin
        m_cnt = 0; m_rep = (m_rep == 0) ? int'(rep_cfg) : m_rep - 1;
      end else if (run) begin
        m_cnt = (m_cnt + 1) % 65536;
      end
      m_trg_p = trg_in;
    end
  end

  function automatic logic [CW-1:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return CW'(m_flag);
      2'd1:    return CW'(m_ien);
      2'd2:    return CW'(m_ccr[0]);
      default: return CW'(m_ccr[1]);
    endcase
  endfunction

  task automatic chk(string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then the caller drives
  task automatic cyc();
    @(negedge clk);
    chk("rdata", bus_rdata, exp_rd(bus_addr));
    chk("irq", CW'(irq), CW'(|(m_flag & m_ien)));
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
    bus_wr = 0; bus_addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a);
    bus_addr = a; bus_rd = 1;
    cyc();
    bus_rd = 0; bus_addr = 2'd0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values and reserved bits
    cur_req = "R1";
    chk("status after reset", bus_rdata, 16'h0000);
    chk("irq after reset", CW'(irq), 16'h0000);
    reload = 16'd200;
    rd(2'd1); rd(2'd2); rd(2'd3);
    // R2: writing ones leaves flags alone, zeros clear
    cur_req = "R2";
    wr(2'd0, 16'hFFFF); run_n(2);
    wr(2'd0, 16'h0000); run_n(2);
    // R9 / R10: wrapping and repetition
    cur_req = "R10";
    reload = 16'd5; rep_cfg = 8'd2;
    ug = 1; cyc(); ug = 0;
    wr(2'd1, 16'h0001);
    for (int k = 0; k < 6; k++) begin run_n(5); wr(2'd0, 16'h00FE); end
    cur_req = "R9";
    rep_cfg = 8'd0;
    run_n(14);
    wr(2'd0, 16'h0000);
    cur_req = "R10";
    udis = 1; run_n(12); wr(2'd0, 16'h0000); run_n(4); udis = 0;
    // R11: restart under each urs/udis combination
    cur_req = "R11";
    for (int u = 0; u < 4; u++) begin
      urs = u[0]; udis = u[1];
      wr(2'd0, 16'h0000);
      ug = 1; cyc(); ug = 0;
      run_n(2);
    end
    urs = 0; udis = 0; reload = 16'd40;
    wr(2'd0, 16'h0000);
    // R4: trigger, ungated then gated
    cur_req = "R4";
    wr(2'd1, 16'h0040);
    trg_in = 1; run_n(3); trg_in = 0; run_n(3);
    wr(2'd0, 16'h0000); run_n(2);
    trg_in = 1; cyc(); trg_in = 0; run_n(2);
    gated = 1;
    wr(2'd0, 16'h0000);
    run_n(3);
    trg_in = 1; run_n(6); wr(2'd0, 16'h0000);
    trg_in = 0; run_n(4); wr(2'd0, 16'h0000);
    gated = 0; reload = 16'd5;
    ug = 1; cyc(); ug = 0;
    // R3: break flag and conditional clear
    cur_req = "R3";
    wr(2'd1, 16'h0080);
    brk_in = 1; run_n(2);
    wr(2'd0, 16'h0000); run_n(2);
    cur_req = "R3";
    chk("break held", bus_rdata & 16'h0080, 16'h0080);
    brk_in = 0; run_n(1);
    wr(2'd0, 16'h0000); run_n(2);
    // R5: COM strobe, and R2 set against same-cycle clear
    cur_req = "R5";
    wr(2'd1, 16'h0020);
    com_stb = 1; cyc(); com_stb = 0; run_n(3);
    wr(2'd0, 16'h00DF); run_n(2);
    cur_req = "R2";
    com_stb = 1; bus_addr = 2'd0; bus_wdata = 16'h0000; bus_wr = 1;
    cyc(); com_stb = 0; bus_wr = 0;
    cyc();
    chk("set beats clear", bus_rdata & 16'h0020, 16'h0020);
    wr(2'd0, 16'h0000);
    // R6: compare match inside and above the reload range
    cur_req = "R6";
    wr(2'd1, 16'h0006);
    wr(2'd2, 16'd3); wr(2'd3, 16'd20);
    for (int k = 0; k < 5; k++) begin run_n(4); wr(2'd0, 16'h0000); end
    wr(2'd2, 16'd5); wr(2'd3, 16'd6);
    for (int k = 0; k < 4; k++) begin run_n(3); wr(2'd0, 16'h0000); end
    // R7: captures with each polarity
    cur_req = "R7";
    reload = 16'd100;
    ch_mode = 2'b11; ch_pol = 4'b0100;
    for (int p = 0; p < 3; p++) begin
      ch_pol = (p == 0) ? 4'b0100 : (p == 1) ? 4'b0001 : 4'b1011;
      for (int k = 0; k < 4; k++) begin
        ic_in = ic_in ^ 2'b11; run_n(3);
        bus_addr = 2'(2 + (k % 2)); run_n(1); bus_addr = 2'd0;
      end
      wr(2'd0, 16'h0000);
    end
    ic_in = 2'b00; ch_pol = 4'b0000; run_n(1);
    ic_in = 2'b01; bus_addr = 2'd2; bus_wdata = 16'h0ABC; bus_wr = 1;
    cyc(); bus_wr = 0; cyc();
    // R8: read clears in capture, not in compare
    cur_req = "R8";
    ic_in = 2'b10; run_n(2);
    rd(2'd2); rd(2'd3); run_n(2);
    ch_mode = 2'b00; wr(2'd2, 16'd500); wr(2'd3, 16'd500);
    ic_in = 2'b00; ch_mode = 2'b11; run_n(1);
    ic_in = 2'b11; cyc(); ic_in = 2'b00; ch_mode = 2'b00;
    rd(2'd2); rd(2'd3); run_n(2);
    chk("compare read keeps", bus_rdata & 16'h0006, 16'h0006);
    // R12: interrupt masking
    cur_req = "R12";
    wr(2'd1, 16'h0000); run_n(2);
    wr(2'd1, 16'h0004); run_n(2);
    wr(2'd0, 16'h0000); run_n(2);
    // random mix, reload fixed
    cur_req = "R9";
    reload = 16'd9;
    for (int k = 0; k < 600; k++) begin
      trg_in  = ($urandom % 6) == 0 ? ~trg_in : trg_in;
      gated   = (k / 150) % 2 == 1;
      ug      = ($urandom % 20) == 0;
      udis    = ($urandom % 5) == 0;
      urs     = ($urandom % 3) == 0;
      rep_cfg = 8'($urandom % 3);
      ch_mode = 2'($urandom);
      ch_pol  = 4'($urandom);
      ic_in   = 2'($urandom);
      brk_in  = ($urandom % 8) == 0;
      com_stb = ($urandom % 10) == 0;
      bus_addr = 2'($urandom);
      bus_rd  = ($urandom % 4) == 0;
      bus_wr  = ($urandom % 5) == 0;
      bus_wdata = (bus_addr >= 2'd2) ? CW'($urandom % 14) : CW'($urandom);
      cyc();
    end
    bus_wr = 0; bus_rd = 0; ug = 0; com_stb = 0;
    run_n(3);
    finish_up();
  end

endmodule